// File: doc/BRIEF.md
# Raster Timing Generator with Slave Line Re-alignment

This block produces the horizontal and vertical timing of a 525-line, 59.94 Hz text display from a single 6.041957 MHz reference clock. One line lasts 384 reference clocks. Each field has 262 lines, or 263 and 262 lines in turn when interlace is on. From its counters the block derives a composite sync, the character row and the scan line within that row, a flag marking where character dots appear, and a secondary timing strobe.

As a master, the horizontal counter runs freely. In slave mode the block follows an incoming composite sync: a falling edge on that input forces the horizontal counter back to zero and starts a new line. An edge that lands within two clocks of the counter's own wrap is ignored, so that a source with nearly the same phase does not cause a reset on every line and the picture does not jitter. Vertical alignment is reduced to a synchronous vertical reset input. All inputs are assumed synchronous to the reference clock.

Top module: `vt_timing_chain`

## Requirements
- R1: As a master, `h_count` counts 0 to 383 and then returns to 0. Each line lasts 384 clocks.
- R2: `v_line` advances once per line. With interlace off, a field has 262 lines (0 to 261) and `field_odd` stays 0. With interlace on, a field with `field_odd`=0 has 263 lines and a field with `field_odd`=1 has 262 lines. `field_odd` toggles at each field wrap.
- R3: On ordinary lines, `csync_n` is low while `h_count` < 28 and high otherwise. On lines 3, 4 and 5 the polarity is inverted, which forms broad pulses.
- R4: Suppose `slave_en`=1, `ext_sync_n` was high at the previous clock edge and is low at this edge, and `h_count` is between 2 and 381. Then `h_count` is 0 after this edge, and the line counts as ended.
- R5: A falling edge that arrives while `h_count` is 382, 383, 0 or 1 is ignored, and the count goes on by one. With `slave_en`=0, every falling edge is ignored.
- R6: With `rows25_en`=0, active lines are 20 to 229 in 21 rows of 10 scan lines. `row_idx` = (`v_line`-20)/10 and `scan_idx` = (`v_line`-20)%10. Both are 0 outside the active lines.
- R7: With `rows25_en`=1, active lines are 20 to 244 in 25 rows of 9 scan lines, so `row_idx` = (`v_line`-20)/9 and `scan_idx` = (`v_line`-20)%9.
- R8: `disp_area` is 1 exactly on active lines while 80 ≤ `h_count` < 320, which is 40 characters of 6 clocks each.
- R9: With `aux_full`=0, `aux_tick` is 1 on one clock in six, first on the sixth clock after reset. With `aux_full`=1, it is 1 on every clock.
- R10: `vreset`=1 sets `v_line`, `row_idx` and `scan_idx` to 0 after the edge and leaves `field_odd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 6.041957 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_en | input | 1 | 1: follow the incoming sync; 0: free-running master |
| ext_sync_n | input | 1 | Incoming composite sync, active low |
| vreset | input | 1 | Vertical reset, returns the line count to 0 |
| interlace_en | input | 1 | Selects alternating 263/262-line fields |
| rows25_en | input | 1 | Selects 25 rows of 9 lines instead of 21 rows of 10 |
| aux_full | input | 1 | Secondary strobe at the full rate instead of divided by 6 |
| csync_n | output | 1 | Composite sync, active low |
| h_count | output | 9 | Horizontal position in reference clocks |
| v_line | output | 9 | Line number within the field |
| field_odd | output | 1 | Field parity |
| row_idx | output | 5 | Character row on active lines |
| scan_idx | output | 4 | Scan line within the character row |
| disp_area | output | 1 | Character dots are being output |
| aux_tick | output | 1 | Secondary timing strobe |

## Verification
A wrong horizontal state shows up on `h_count` and `csync_n` on the next clock, and the position error it leaves behind lasts until the next re-alignment. A missed or spurious re-alignment puts `v_line` and the row and scan counts one line off from that point until the field wraps. A field-length or parity error appears only at a field boundary, so the bench fast-forwards through whole fields with sync edges placed early in each line. A row or scan counter that drifts away from the line number is caught on the first active line where the two disagree.

// File: rtl/vt_pkg.sv
// Shared timing constants for the raster timing generator.
// Assumes a 6.041957 MHz reference and a 525-line, 59.94 Hz raster.
package vt_pkg;
    localparam int H_TOTAL_D     = 384;  // reference clocks per line
    localparam int HS_WIDTH_D    = 28;   // line sync width
    localparam int DEAD_D        = 2;    // guard around the wrap, each side
    localparam int ACT_H0_D      = 80;   // first dot position
    localparam int CHARS_D       = 40;   // characters per row
    localparam int CHAR_W_D      = 6;    // clocks per character
    localparam int FIELD_LINES_D = 262;  // lines in a short field
    localparam int VS_FIRST_D    = 3;    // first broad-pulse line
    localparam int VS_LAST_D     = 5;    // last broad-pulse line
    localparam int V_ACT_D       = 20;   // first active line
    localparam int ROWS_A_D      = 21;
    localparam int LPR_A_D       = 10;
    localparam int ROWS_B_D      = 25;
    localparam int LPR_B_D       = 9;
    localparam int AUX_DIV_D     = 6;
endpackage

// File: rtl/vt_hcount.sv
// Horizontal counter. Wraps after H_TOTAL clocks. In slave mode, a falling
// edge on ext_sync_n reloads it with zero, unless the edge lands within
// DEAD clocks of the wrap on either side. Assumes ext_sync_n is synchronous.
module vt_hcount #(
    parameter int H_TOTAL = vt_pkg::H_TOTAL_D,
    parameter int DEAD    = vt_pkg::DEAD_D,
    localparam int HW     = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_en,
    input  logic          ext_sync_n,
    output logic [HW-1:0] h_count,
    output logic          line_end
);
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] DEAD_HI  = HW'(H_TOTAL - DEAD);
    localparam logic [HW-1:0] DEAD_LO  = HW'(DEAD);

    logic sync_q;
    logic sync_fall;
    logic in_dead;
    logic resync;

    // Remember the previous sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b1;
        else        sync_q <= ext_sync_n;
    end

    // Decide whether this clock ends the line.
    always_comb begin
        sync_fall = slave_en && sync_q && !ext_sync_n;
        in_dead   = (h_count >= DEAD_HI) || (h_count < DEAD_LO);
        resync    = sync_fall && !in_dead;
        line_end  = (h_count == H_LAST) || resync;
    end

    // Advance or reload the horizontal position.
    always_ff @(posedge clk) begin
        if (!rst_n)        h_count <= '0;
        else if (line_end) h_count <= '0;
        else               h_count <= h_count + HW'(1);
    end

    p_h_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        h_count <= H_LAST);
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (h_count == H_LAST) |=> (h_count == '0));
    p_resync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && sync_q && !ext_sync_n && h_count >= DEAD_LO && h_count < DEAD_HI)
        |=> (h_count == '0));
    p_dead_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && h_count < DEAD_LO) |=> (h_count == $past(h_count) + HW'(1)));
    p_master_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_en && h_count != H_LAST) |=> (h_count == $past(h_count) + HW'(1)));
endmodule

// File: rtl/vt_vcount.sv
// Vertical counters. Tracks the line within the field and the field parity,
// and keeps the character row and scan counters step by step with the line.
// Assumes rows25_en and interlace_en change only while reset is held.
module vt_vcount #(
    parameter int FIELD_LINES = vt_pkg::FIELD_LINES_D,
    parameter int VS_FIRST    = vt_pkg::VS_FIRST_D,
    parameter int VS_LAST     = vt_pkg::VS_LAST_D,
    parameter int V_ACT       = vt_pkg::V_ACT_D,
    parameter int ROWS_A      = vt_pkg::ROWS_A_D,
    parameter int LPR_A       = vt_pkg::LPR_A_D,
    parameter int ROWS_B      = vt_pkg::ROWS_B_D,
    parameter int LPR_B       = vt_pkg::LPR_B_D,
    localparam int VW         = $clog2(FIELD_LINES + 1),
    localparam int RW         = $clog2((ROWS_A > ROWS_B) ? ROWS_A : ROWS_B),
    localparam int SW         = $clog2((LPR_A > LPR_B) ? LPR_A : LPR_B)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic          vreset,
    input  logic          interlace_en,
    input  logic          rows25_en,
    output logic [VW-1:0] v_line,
    output logic          field_odd,
    output logic [RW-1:0] row_idx,
    output logic [SW-1:0] scan_idx,
    output logic          v_active,
    output logic          v_sync
);
    localparam logic [VW-1:0] ACT_LAST_A = VW'(V_ACT + ROWS_A * LPR_A - 1);
    localparam logic [VW-1:0] ACT_LAST_B = VW'(V_ACT + ROWS_B * LPR_B - 1);

    logic [VW-1:0] last_line;
    logic [VW-1:0] act_last;
    logic [SW-1:0] scan_last;
    logic [RW-1:0] rows_n;

    // Select field length and row geometry for the current mode.
    always_comb begin
        last_line = (interlace_en && !field_odd) ? VW'(FIELD_LINES) : VW'(FIELD_LINES - 1);
        act_last  = rows25_en ? ACT_LAST_B : ACT_LAST_A;
        scan_last = rows25_en ? SW'(LPR_B - 1) : SW'(LPR_A - 1);
        rows_n    = rows25_en ? RW'(ROWS_B) : RW'(ROWS_A);
        v_active  = (v_line >= VW'(V_ACT)) && (v_line <= act_last);
        v_sync    = (v_line >= VW'(VS_FIRST)) && (v_line <= VW'(VS_LAST));
    end

    // Step line, field, row and scan at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_line    <= '0;
            field_odd <= 1'b0;
            row_idx   <= '0;
            scan_idx  <= '0;
        end else if (vreset) begin
            v_line   <= '0;
            row_idx  <= '0;
            scan_idx <= '0;
        end else if (line_end) begin
            if (v_line == last_line) begin
                v_line    <= '0;
                field_odd <= interlace_en ? !field_odd : 1'b0;
                row_idx   <= '0;
                scan_idx  <= '0;
            end else begin
                v_line <= v_line + VW'(1);
                if (v_active) begin
                    if (v_line == act_last) begin
                        row_idx  <= '0;
                        scan_idx <= '0;
                    end else if (scan_idx == scan_last) begin
                        scan_idx <= '0;
                        row_idx  <= row_idx + RW'(1);
                    end else begin
                        scan_idx <= scan_idx + SW'(1);
                    end
                end
            end
        end
    end

    p_vline_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_line <= VW'(FIELD_LINES));
    p_scan_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_idx <= scan_last);
    p_row_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx < rows_n);
    p_vreset_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vreset |=> (v_line == '0 && row_idx == '0 && scan_idx == '0));
    p_vreset_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vreset |=> $stable(field_odd));
endmodule

// File: rtl/vt_auxdiv.sv
// Secondary strobe. Pulses once every DIV reference clocks, or on every
// clock when aux_full is set. Assumes DIV is at least 2.
module vt_auxdiv #(
    parameter int DIV = vt_pkg::AUX_DIV_D,
    localparam int CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_full,
    output logic aux_tick
);
    logic [CW-1:0] div_cnt;

    // Free-running divider.
    always_ff @(posedge clk) begin
        if (!rst_n)                       div_cnt <= '0;
        else if (div_cnt == CW'(DIV - 1)) div_cnt <= '0;
        else                              div_cnt <= div_cnt + CW'(1);
    end

    // Choose divided or full-rate strobe.
    always_comb aux_tick = aux_full || (div_cnt == CW'(DIV - 1));

    p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_tick && !aux_full) |=> (!aux_tick || aux_full));
endmodule

// File: rtl/vt_timing_chain.sv
// Raster timing generator top. Joins the horizontal and vertical counters
// and the strobe divider, then decodes composite sync and the dot area.
// Assumes every input is synchronous to clk.
module vt_timing_chain #(
    parameter int H_TOTAL     = vt_pkg::H_TOTAL_D,
    parameter int HS_WIDTH    = vt_pkg::HS_WIDTH_D,
    parameter int DEAD        = vt_pkg::DEAD_D,
    parameter int ACT_H0      = vt_pkg::ACT_H0_D,
    parameter int CHARS       = vt_pkg::CHARS_D,
    parameter int CHAR_W      = vt_pkg::CHAR_W_D,
    parameter int FIELD_LINES = vt_pkg::FIELD_LINES_D,
    parameter int AUX_DIV     = vt_pkg::AUX_DIV_D,
    localparam int HW         = $clog2(H_TOTAL),
    localparam int VW         = $clog2(FIELD_LINES + 1),
    localparam int RW         = $clog2(vt_pkg::ROWS_B_D),
    localparam int SW         = $clog2(vt_pkg::LPR_A_D)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_en,
    input  logic          ext_sync_n,
    input  logic          vreset,
    input  logic          interlace_en,
    input  logic          rows25_en,
    input  logic          aux_full,
    output logic          csync_n,
    output logic [HW-1:0] h_count,
    output logic [VW-1:0] v_line,
    output logic          field_odd,
    output logic [RW-1:0] row_idx,
    output logic [SW-1:0] scan_idx,
    output logic          disp_area,
    output logic          aux_tick
);
    localparam logic [HW-1:0] ACT_H_END = HW'(ACT_H0 + CHARS * CHAR_W);

    logic line_end;
    logic v_active;
    logic v_sync;
    logic h_sync;

    vt_hcount #(.H_TOTAL(H_TOTAL), .DEAD(DEAD)) u_h (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .ext_sync_n(ext_sync_n),
        .h_count(h_count), .line_end(line_end));

    vt_vcount #(.FIELD_LINES(FIELD_LINES)) u_v (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .vreset(vreset),
        .interlace_en(interlace_en), .rows25_en(rows25_en),
        .v_line(v_line), .field_odd(field_odd), .row_idx(row_idx),
        .scan_idx(scan_idx), .v_active(v_active), .v_sync(v_sync));

    vt_auxdiv #(.DIV(AUX_DIV)) u_aux (
        .clk(clk), .rst_n(rst_n), .aux_full(aux_full), .aux_tick(aux_tick));

    // Decode sync polarity and the character dot window.
    always_comb begin
        h_sync    = h_count < HW'(HS_WIDTH);
        csync_n   = v_sync ? h_sync : !h_sync;
        disp_area = v_active && (h_count >= HW'(ACT_H0)) && (h_count < ACT_H_END);
    end

    p_broad_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_line == VW'(vt_pkg::VS_FIRST_D) && h_count == '0) |-> csync_n);
    p_disp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_area |-> (csync_n && v_line >= VW'(vt_pkg::V_ACT_D)));
endmodule

// File: tb/tb_vt_timing_chain.sv
`timescale 1ns/1ps
module tb_vt_timing_chain;
    localparam int HT = 384, FL = 262;

    logic clk = 0, rst_n = 0;
    logic slave_en = 0, ext_sync_n = 1, vreset = 0;
    logic interlace_en = 1, rows25_en = 0, aux_full = 0;
    logic csync_n, field_odd, disp_area, aux_tick;
    logic [8:0] h_count, v_line;
    logic [4:0] row_idx;
    logic [3:0] scan_idx;

    int total = 0, bad = 0;
    bit started = 0, done = 0;
    int m_h = 0, m_v = 0, m_f = 0, m_div = 0, m_sprev = 1;

    always #5 clk = ~clk;

    vt_timing_chain dut (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .ext_sync_n(ext_sync_n),
        .vreset(vreset), .interlace_en(interlace_en), .rows25_en(rows25_en),
        .aux_full(aux_full), .csync_n(csync_n), .h_count(h_count), .v_line(v_line),
        .field_odd(field_odd), .row_idx(row_idx), .scan_idx(scan_idx),
        .disp_area(disp_area), .aux_tick(aux_tick));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (h=%0d v=%0d)", req, act, exp, m_h, m_v);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 0; m_v = 0; m_f = 0; m_div = 0; m_sprev = 1;
        end else begin
            bit fall, dead, lend;
            int flen;
            fall = slave_en && m_sprev && !ext_sync_n;
            dead = (m_h >= HT - 2) || (m_h < 2);
            lend = (m_h == HT - 1) || (fall && !dead);
            flen = interlace_en ? (m_f ? FL : FL + 1) : FL;
            m_h = lend ? 0 : m_h + 1;
            if (vreset) m_v = 0;
            else if (lend) begin
                if (m_v == flen - 1) begin
                    m_v = 0;
                    m_f = interlace_en ? 1 - m_f : 0;
                end else m_v++;
            end
            m_div = (m_div == 5) ? 0 : m_div + 1;
            m_sprev = ext_sync_n;
        end
        started = 1;
    end

    // Compare every output shortly after each falling edge.
    always @(negedge clk) if (started && !done) begin
        int lpr, nrows, rel, erow, escan, act, hs, ecs;
        #1;
        lpr = rows25_en ? 9 : 10;
        nrows = rows25_en ? 25 : 21;
        act = (m_v >= 20) && (m_v < 20 + nrows * lpr);
        rel = m_v - 20;
        erow = act ? rel / lpr : 0;
        escan = act ? rel % lpr : 0;
        hs = m_h < 28;
        ecs = (m_v >= 3 && m_v <= 5) ? hs : !hs;
        chk("R1 h_count", h_count, m_h);
        chk("R2 v_line", v_line, m_v);
        chk("R2 field_odd", field_odd, m_f);
        chk("R3 csync_n", csync_n, ecs);
        chk(rows25_en ? "R7 row_idx" : "R6 row_idx", row_idx, erow);
        chk(rows25_en ? "R7 scan_idx" : "R6 scan_idx", scan_idx, escan);
        chk("R8 disp_area", disp_area, act && m_h >= 80 && m_h < 320);
        chk("R9 aux_tick", aux_tick, aux_full ? 1 : (m_div == 5));
    end

    // Issue one falling edge on the incoming sync when h reaches x.
    task automatic sync_at(input int x);
        int exp;
        while (m_h != x) @(negedge clk);
        exp = (!slave_en || x >= HT - 2 || x < 2) ? (x + 1) % HT : 0;
        ext_sync_n = 0;
        @(negedge clk);
        ext_sync_n = 1;
        #2;
        if (exp == 0) chk("R4 resync to zero", h_count, exp);
        else          chk("R5 edge ignored", h_count, exp);
    endtask

    task automatic advance_to(input int line, input int fld);
        while (!(m_v == line && m_f == fld)) sync_at(40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk("R1 reset h_count", h_count, 0);
        chk("R2 reset v_line", v_line, 0);
        rst_n = 1;
        repeat (800) @(negedge clk);                  // master lines (R1, R3)
        slave_en = 1;
        advance_to(25, 0);                            // into active rows (R6)
        repeat (2 * HT) @(negedge clk);               // full active lines (R8)
        sync_at(382); sync_at(1); sync_at(0); sync_at(200); sync_at(2); sync_at(381);
        slave_en = 0;
        sync_at(100);                                 // master ignores edge (R5)
        slave_en = 1;
        aux_full = 1; repeat (20) @(negedge clk); aux_full = 0;   // R9
        advance_to(262, 0);                           // 263-line even field (R2)
        advance_to(5, 1);                             // broad pulses (R3)
        advance_to(40, 1);
        vreset = 1; @(negedge clk); vreset = 0;
        #2;
        chk("R10 vreset line", v_line, 0);
        chk("R10 vreset field kept", field_odd, 1);
        advance_to(0, 0);                             // 262-line odd field (R2)
        rst_n = 0; interlace_en = 0; rows25_en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        advance_to(30, 0);
        repeat (HT) @(negedge clk);                   // R7 geometry, R8
        while (m_v != 261) sync_at(40);
        sync_at(40);
        #2;
        chk("R2 non-interlaced wrap", v_line, 0);
        chk("R2 parity stays", field_odd, 0);
        advance_to(250, 0);
        repeat (HT) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule